// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one read or write transfer at a time on a local processor bus. On that bus the low lines carry first an address and then data, and the top address lines also carry cycle status. A core-side request gives a 20-bit address, a memory-or-port selector, a read/write flag, an upper-byte enable, a 2-bit segment code, and write data. The block latches the request and steps through the bus states T1, T2, any number of TW wait states, T3 and T4. In each state it drives the address strobe, the read and write strobes, the buffer direction and buffer enable, and the status lines. It returns the read data to the core.

The pad ring sits outside the block. The shared low lines are therefore split into a driven value, an output enable, and a sampled input. A READY input lengthens the transfer: each low sample adds one wait state between T2 and T3. A busy flag and a single-cycle done pulse tell the core when it can issue the next request.

Top module: `mux_bus_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are in this state: busy=0, done=0, ale=0, rd_n=1, wr_n=1, ad_oe=0, den=0.
- R2: A request with req_valid=1 while busy=0 is accepted at the next clock edge, and the following cycle is T1. In T1: ale=1, ad_oe=1, ad_out equals address bits 15..0, a_hi_s equals address bits 19..16, and bhe_s7 equals the inverse of req_bhe. ALE is high in T1 only.
- R3: From T2 through T4, a_hi_s carries status. Bit 3 is 0. Bit 2 is the if_flag value captured when the request was accepted. Bits 1..0 are the segment code captured with the request.
- R4: From T2 through T4, bhe_s7 is 1.
- R5: For a read, rd_n is 0 in T2, in every TW and in T3, and 1 otherwise. For a write, wr_n behaves the same way. The two strobes are never 0 together.
- R6: READY is sampled at the end of T2 and at the end of each TW. A low sample leads to one more TW, and a high sample leads to T3. A transfer with N low samples therefore lasts 4+N cycles.
- R7: For a read, ad_oe is 0 from T2 through T4. ad_in is captured at the end of T3 and appears on rd_data from T4 onward. rd_data keeps that value until the next read.
- R8: For a write, ad_oe=1 and ad_out equals the write data from T2 through T4.
- R9: From T1 through T4, m_io is 1 for a memory transfer (req_io=0) and 0 for a port transfer, and dt_r is 1 for a write and 0 for a read. den is 1 from T2 through T3 for a read and from T2 through T4 for a write.
- R10: busy is 1 from T1 through T4, and done is 1 only in T4. req_valid has no effect while busy=1. Request inputs that change after acceptance do not change the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests a transfer |
| req_addr | input | 20 | Transfer address |
| req_io | input | 1 | 1 = port space, 0 = memory space |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bhe | input | 1 | Upper data byte enabled (active high) |
| req_seg | input | 2 | Segment code placed on status bits 1..0 |
| req_wdata | input | 16 | Write data |
| if_flag | input | 1 | Interrupt-enable flag, captured at accept |
| ready | input | 1 | Low asks for a wait state |
| ad_in | input | 16 | Sampled value of the shared low lines |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse in T4 |
| rd_data | output | 16 | Data captured by the last read |
| ad_out | output | 16 | Value driven onto the shared low lines |
| ad_oe | output | 1 | Output enable for the shared low lines |
| a_hi_s | output | 4 | Address bits 19..16 in T1, status afterwards |
| bhe_s7 | output | 1 | Upper-byte enable (active low) in T1, 1 afterwards |
| ale | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 = memory, 0 = port |
| dt_r | output | 1 | Buffer direction, 1 = transmit |
| den | output | 1 | Buffer enable |

## Verification
The hardest situation to reach is a long string of wait states: READY must stay low across several consecutive sample points and then rise at exactly one of them. The bench computes which cycle holds the last sample and drives READY at the falling edge before it. It draws the wait count at random from 0 to 7. It also checks that inputs changed during a transfer are ignored: it scrambles the address, if_flag and req_valid mid-transfer and expects the latched values on the status lines.

// File: rtl/mbs_pkg.sv
// Package: shared state encoding for the multiplexed bus sequencer.
// Assumes: one transfer at a time, states visited T1,T2,{TW},T3,T4.
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bus_st_e;
endpackage

// File: rtl/mbs_fsm.sv
// Module: bus state sequencer.
// Steps IDLE->T1->T2->{TW}*->T3->T4->IDLE. READY is sampled on the edge
// leaving T2 or TW. Assumes ready is already synchronous to clk.
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready,
    output bus_st_e st,
    output logic    accept
);
    bus_st_e st_nxt;

    // Acceptance happens only from IDLE.
    assign accept = (st == ST_IDLE) && req_valid;

    // Next-state selection.
    always_comb begin
        st_nxt = st;
        case (st)
            ST_IDLE: if (req_valid) st_nxt = ST_T1;
            ST_T1:   st_nxt = ST_T2;
            ST_T2:   st_nxt = ready ? ST_T3 : ST_TW;
            ST_TW:   st_nxt = ready ? ST_T3 : ST_TW;
            ST_T3:   st_nxt = ST_T4;
            ST_T4:   st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end
endmodule

// File: rtl/mbs_req_reg.sv
// Module: request holding register.
// Captures all request fields and the interrupt flag on acceptance.
// They stay fixed for the whole transfer. Assumes accept is a single cycle.
module mbs_req_reg #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_wr,
    input  logic              req_bhe,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              if_flag,
    output logic [ADDR_W-1:0] l_addr,
    output logic              l_io,
    output logic              l_wr,
    output logic              l_bhe,
    output logic [SEG_W-1:0]  l_seg,
    output logic [DATA_W-1:0] l_wdata,
    output logic              l_ifl
);
    // Latch the request fields when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_addr  <= '0;
            l_io    <= 1'b0;
            l_wr    <= 1'b0;
            l_bhe   <= 1'b0;
            l_seg   <= '0;
            l_wdata <= '0;
            l_ifl   <= 1'b0;
        end else if (accept) begin
            l_addr  <= req_addr;
            l_io    <= req_io;
            l_wr    <= req_wr;
            l_bhe   <= req_bhe;
            l_seg   <= req_seg;
            l_wdata <= req_wdata;
            l_ifl   <= if_flag;
        end
    end
endmodule

// File: rtl/mbs_ctl.sv
// Module: control strobe decoder.
// Produces ALE, the read/write strobes, the buffer controls and the
// busy/done flags from the registered state. The outputs are decoded from
// flops only, so each changes at most once per clock.
module mbs_ctl
    import mbs_pkg::*;
(
    input  bus_st_e st,
    input  logic    l_wr,
    input  logic    l_io,
    output logic    ale,
    output logic    rd_n,
    output logic    wr_n,
    output logic    den,
    output logic    dt_r,
    output logic    m_io,
    output logic    busy,
    output logic    done,
    output logic    ad_oe
);
    logic in_t1, strobe_win, in_t4, active;

    // State window decode.
    always_comb begin
        in_t1      = (st == ST_T1);
        in_t4      = (st == ST_T4);
        strobe_win = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
        active     = (st != ST_IDLE);
    end

    // Strobe, buffer and flag outputs.
    always_comb begin
        ale   = in_t1;
        rd_n  = !(strobe_win && !l_wr);
        wr_n  = !(strobe_win && l_wr);
        den   = strobe_win || (in_t4 && l_wr);
        dt_r  = active && l_wr;
        m_io  = active && !l_io;
        busy  = active;
        done  = in_t4;
        ad_oe = in_t1 || (l_wr && (strobe_win || in_t4));
    end
endmodule

// File: rtl/mbs_lines.sv
// Module: multiplexed line driver and read capture.
// Drives the low lines (address in T1, write data afterwards) and the upper
// lines (address in T1, status afterwards). Captures read data at the end
// of T3. Assumes ADDR_W - DATA_W equals 2 + SEG_W (status S6,S5,seg).
module mbs_lines
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_st_e           st,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_bhe,
    input  logic [SEG_W-1:0]  l_seg,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_ifl,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   a_hi_s,
    output logic              bhe_s7,
    output logic [DATA_W-1:0] rd_data
);
    logic [HI_W-1:0] status;
    logic            in_t1, idle;

    assign in_t1 = (st == ST_T1);
    assign idle  = (st == ST_IDLE);
    // Status word: top bit fixed 0, then interrupt flag, then segment code.
    assign status = {1'b0, l_ifl, l_seg};

    // Low lines carry the address in T1 and the write data afterwards.
    always_comb begin
        if (in_t1)     ad_out = l_addr[DATA_W-1:0];
        else if (l_wr) ad_out = l_wdata;
        else           ad_out = '0;
    end

    // Upper lines: address in T1, status in the later bus states, 0 when idle.
    for (genvar g = 0; g < HI_W; g++) begin : g_hi
        assign a_hi_s[g] = idle  ? 1'b0 :
                           in_t1 ? l_addr[DATA_W+g] : status[g];
    end

    // Upper-byte enable (active low) in T1, fixed high otherwise.
    assign bhe_s7 = in_t1 ? !l_bhe : 1'b1;

    // Capture read data on the edge that leaves T3.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_data <= '0;
        else if (st == ST_T3 && !l_wr)   rd_data <= ad_in;
    end
endmodule

// File: rtl/mux_bus_seq.sv
// Module: multiplexed address/data bus cycle sequencer (top).
// Runs one read or write transfer per accepted request with READY-controlled
// wait states. The shared low lines are split into ad_out/ad_oe/ad_in for an
// external pad. Assumes synchronous inputs and a single requester.
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_wr,
    input  logic              req_bhe,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              if_flag,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi_s,
    output logic              bhe_s7,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              m_io,
    output logic              dt_r,
    output logic              den
);
    bus_st_e           st;
    logic              accept;
    logic [ADDR_W-1:0] l_addr;
    logic              l_io, l_wr, l_bhe, l_ifl;
    logic [SEG_W-1:0]  l_seg;
    logic [DATA_W-1:0] l_wdata;

    mbs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
        .st(st), .accept(accept)
    );

    mbs_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_req (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_addr(req_addr), .req_io(req_io), .req_wr(req_wr),
        .req_bhe(req_bhe), .req_seg(req_seg), .req_wdata(req_wdata),
        .if_flag(if_flag),
        .l_addr(l_addr), .l_io(l_io), .l_wr(l_wr), .l_bhe(l_bhe),
        .l_seg(l_seg), .l_wdata(l_wdata), .l_ifl(l_ifl)
    );

    mbs_ctl u_ctl (
        .st(st), .l_wr(l_wr), .l_io(l_io),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den(den), .dt_r(dt_r),
        .m_io(m_io), .busy(busy), .done(done), .ad_oe(ad_oe)
    );

    mbs_lines #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .st(st),
        .l_addr(l_addr), .l_wr(l_wr), .l_bhe(l_bhe), .l_seg(l_seg),
        .l_wdata(l_wdata), .l_ifl(l_ifl), .ad_in(ad_in),
        .ad_out(ad_out), .a_hi_s(a_hi_s), .bhe_s7(bhe_s7), .rd_data(rd_data)
    );
endmodule

// File: rtl/mbs_chk.sv
// Module: protocol checker for mux_bus_seq, attached by bind.
// Observes ports plus the sequencer state; drives nothing.
module mbs_chk
    import mbs_pkg::*;
#(
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input bus_st_e         st,
    input logic            ready,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            busy,
    input logic            done,
    input logic            ad_oe,
    input logic [HI_W-1:0] a_hi_s,
    input logic            bhe_s7
);
    // R2: the address strobe lasts exactly one cycle.
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    // R5: read and write strobes are never active together.
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R6: a low READY sample in T2 or TW leads to another wait state.
    a_r6_wait_more: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T2 || st == ST_TW) && !ready) |=> (st == ST_TW));
    // R6: a high READY sample in T2 or TW moves on to T3.
    a_r6_wait_end: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T2 || st == ST_TW) && ready) |=> (st == ST_T3));
    // R7: the low lines are released while the read strobe is active.
    a_r7_read_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R3: the top status bit is 0 after T1.
    a_r3_top_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> !a_hi_s[HI_W-1]);
    // R4: the upper-byte line is 1 after T1.
    a_r4_s7_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> bhe_s7);
    // R10: done is a single pulse and the block is idle afterwards.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind mux_bus_seq mbs_chk #(.HI_W(HI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .ready(ready), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done), .ad_oe(ad_oe),
    .a_hi_s(a_hi_s), .bhe_s7(bhe_s7)
);

// File: tb/mux_bus_seq_tb.sv
// Bench: directed corner transfers plus seeded random transfers, checked
// cycle by cycle at the falling edge against expectations from the brief.
module mux_bus_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_io = 1'b0, req_wr = 1'b0, req_bhe = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic        if_flag = 1'b0, ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic        busy, done, ad_oe, bhe_s7, ale, rd_n, wr_n, m_io, dt_r, den;
    logic [15:0] rd_data, ad_out;
    logic [3:0]  a_hi_s;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // expected-transfer record
    logic [19:0] e_addr;
    logic        e_io, e_wr, e_bhe, e_ifl;
    logic [1:0]  e_seg;
    logic [15:0] e_wdata, e_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_io(req_io), .req_wr(req_wr), .req_bhe(req_bhe), .req_seg(req_seg),
        .req_wdata(req_wdata), .if_flag(if_flag), .ready(ready), .ad_in(ad_in),
        .busy(busy), .done(done), .rd_data(rd_data), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi_s(a_hi_s), .bhe_s7(bhe_s7), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den(den)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_status(logic ifl, logic [1:0] seg);
        return {1'b0, ifl, seg};
    endfunction

    // Checks for T2, TW and T3.
    task automatic chk_mid(string st);
        chk({"R2 ale low ", st}, ale, 0);
        chk({"R3 status ", st}, a_hi_s, exp_status(e_ifl, e_seg));
        chk({"R4 s7 ", st}, bhe_s7, 1);
        chk({"R5 rd_n ", st}, rd_n, e_wr);
        chk({"R5 wr_n ", st}, wr_n, !e_wr);
        chk({"R7/R8 ad_oe ", st}, ad_oe, e_wr);
        if (e_wr) chk({"R8 wdata ", st}, ad_out, e_wdata);
        chk({"R9 den ", st}, den, 1);
        chk({"R9 dt_r ", st}, dt_r, e_wr);
        chk({"R9 m_io ", st}, m_io, !e_io);
        chk({"R10 busy ", st}, busy, 1);
        chk({"R10 done ", st}, done, 0);
    endtask

    task automatic run_xfer(logic [19:0] a, logic io, logic wr, logic bhe,
                            logic [1:0] seg, logic ifl, logic [15:0] wd,
                            int nwait, logic [15:0] rv);
        logic [15:0] prev_rd;
        e_addr = a; e_io = io; e_wr = wr; e_bhe = bhe; e_seg = seg;
        e_ifl = ifl; e_wdata = wd;
        @(negedge clk);
        chk("R10 idle before request", busy, 0);
        prev_rd = rd_data;
        req_addr = a; req_io = io; req_wr = wr; req_bhe = bhe; req_seg = seg;
        req_wdata = wd; if_flag = ifl; req_valid = 1'b1; ready = 1'b1;
        @(negedge clk); // T1
        chk("R2 ale T1", ale, 1);
        chk("R2 ad_oe T1", ad_oe, 1);
        chk("R2 addr low T1", ad_out, a[15:0]);
        chk("R2 addr high T1", a_hi_s, a[19:16]);
        chk("R2 bhe T1", bhe_s7, !bhe);
        chk("R5 strobes idle T1", {rd_n, wr_n}, 2'b11);
        chk("R9 m_io T1", m_io, !io);
        chk("R10 busy T1", busy, 1);
        // R10: scramble inputs after acceptance
        req_valid = 1'b0; req_addr = ~a; if_flag = !ifl; req_seg = ~seg;
        req_wdata = ~wd; req_wr = !wr;
        @(negedge clk); // T2
        chk_mid("T2");
        req_valid = 1'b1; // R10 spurious request while busy
        ready = (nwait == 0);
        for (int w = 0; w < nwait; w++) begin
            @(negedge clk); // TW
            chk_mid("TW");
            ready = (w == nwait - 1);
        end
        @(negedge clk); // T3
        chk_mid("T3");
        ad_in = rv; req_valid = 1'b0; ready = $urandom_range(0, 1);
        @(negedge clk); // T4
        chk("R10 done T4", done, 1);
        chk("R5 strobes released T4", {rd_n, wr_n}, 2'b11);
        chk("R7/R8 ad_oe T4", ad_oe, wr);
        chk("R9 den T4", den, wr);
        chk("R3 status T4", a_hi_s, exp_status(ifl, seg));
        e_rd = wr ? prev_rd : rv;
        chk("R7 rd_data T4", rd_data, e_rd);
        ad_in = ~rv;
        @(negedge clk); // IDLE
        chk("R10 idle after T4", busy, 0);
        chk("R10 done cleared", done, 0);
        chk("R7 rd_data held", rd_data, e_rd);
        chk("R7 ad_oe idle", ad_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0086));
        repeat (3) @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 ale reset", ale, 0);
        chk("R1 strobes reset", {rd_n, wr_n}, 2'b11);
        chk("R1 ad_oe reset", ad_oe, 0);
        chk("R1 den reset", den, 0);
        rst_n = 1'b1;
        // directed corners (R6 zero, short, long waits)
        run_xfer(20'hA5A5A, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 16'h0, 0, 16'hBEEF);
        run_xfer(20'h7FFFF, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 16'h1234, 3, 16'h0);
        run_xfer(20'h00040, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 16'hFFFF, 1, 16'h0);
        run_xfer(20'hF0001, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0, 7, 16'h8001);
        // R6 random wait counts
        for (int i = 0; i < 40; i++) begin
            run_xfer(20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     2'($urandom), 1'($urandom), 16'($urandom),
                     $urandom_range(0, 7), 16'($urandom));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule